// File: doc/BRIEF.md
# Top-Two Value Finder

This block keeps a small table of unsigned values. It then reports the largest value and the runner-up, together with the table index where each was found. While the run input is low, the table is filled one entry per clock through a synchronous write port. When run goes high, the block clears its four result registers and walks the table once, from index 0 up to the last index. It fetches one entry per cycle and ranks each fetched entry in the cycle after the fetch. A done flag rises when the walk is complete. It stays high until run is dropped.

Ties have a fixed rule. An entry equal to the current maximum takes over first place, and the previous maximum with its index drops to second place. So with duplicate values the later index wins the higher rank. The four result buses are driven only while the read enable is high and float otherwise. The done flag is always driven.

Top module: `tk_top`

## Requirements
- R1: The table has DEPTH (32) entries of DATA_W (8) unsigned bits. On a rising clock edge where run is 0 and wr_en is 1, din is written to the entry selected by waddr.
- R2: A write request made while run is 1 has no effect on the table.
- R3: On the rising edge where run is first sampled 1 after being 0, all four result registers are cleared to zero.
- R4: Entries are ranked in index order 0 to DEPTH-1. An entry greater than or equal to the current largest becomes the largest with its index, and the previous largest value and its index move to second place.
- R5: An entry smaller than the largest but greater than or equal to the second-largest replaces the second-largest value and its index. Any other entry leaves both unchanged.
- R6: With rd_en at 0, top_val, top_idx, next_val and next_idx are high impedance. With rd_en at 1 they carry the result registers. done is driven in both cases.
- R7: done is 0 during the walk. It rises at the 34th rising edge, counting the edge that first samples run at 1, and at that point all four results are final.
- R8: done and all four results hold while run stays 1. A rising edge with run at 0 clears done.
- R9: Active-low reset clears every table entry, every result register and done.
- R10: Dropping run during a walk aborts it. The next rise of run starts a fresh walk from index 0 with cleared results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | DATA_W | Value to store in the table |
| waddr | input | ADDR_W | Table index for a write |
| wr_en | input | 1 | Write strobe, acted on only while run is 0 |
| mode_run | input | 1 | 0 = fill the table, 1 = find the top two |
| rd_en | input | 1 | 1 = drive the result buses, 0 = float them |
| top_val | output | DATA_W | Largest value |
| next_val | output | DATA_W | Second-largest value |
| top_idx | output | ADDR_W | Index of the largest value |
| next_idx | output | ADDR_W | Index of the second-largest value |
| done | output | 1 | Results are final |

## Verification
The assertions check several properties on every cycle: the second-place value never exceeds the first, the results are zero right after a walk starts, the maximum never shrinks during a walk, no ranking happens once done is set, done holds and then clears with run, and the results stay frozen while done is high. Only the bench's scenarios can show that the ranked values and indices match the tie rule for a given table content. The same goes for the exact cycle at which done rises, for writes during a run being ignored, for the float on the result buses, and for reset emptying the table. The bench sweeps ordered, equal, duplicated-maximum and random tables against an arithmetic model of the result.

// File: rtl/tk_pkg.sv
package tk_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SCAN  = 2'd1,
        PH_DRAIN = 2'd2,
        PH_DONE  = 2'd3
    } phase_e;
endpackage

// File: rtl/tk_store.sv
module tk_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]            rdata;
    } store_s;

    store_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_req) begin
            st_d.mem[wr_addr] = wr_data;
        end
        if (rd_req) begin
            st_d.rdata = st_q.mem[rd_addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdata;
endmodule

// File: rtl/tk_ctrl.sv
module tk_ctrl
    import tk_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_run,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              clear_res,
    output logic              cmp_valid,
    output logic [ADDR_W-1:0] cmp_idx,
    output logic              done
);
    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic              fvalid;
        logic [ADDR_W-1:0] fidx;
        logic              done;
    } ctrl_s;

    ctrl_s cs_d, cs_q;
    logic  start_w;
    logic  fetch_w;

    assign start_w = mode_run && (cs_q.phase == PH_IDLE);
    assign fetch_w = mode_run && (cs_q.phase == PH_SCAN);

    always_comb begin
        cs_d        = cs_q;
        cs_d.fvalid = 1'b0;
        if (!mode_run) begin
            cs_d.phase = PH_IDLE;
            cs_d.addr  = '0;
            cs_d.done  = 1'b0;
        end else begin
            unique case (cs_q.phase)
                PH_IDLE: begin
                    cs_d.phase = PH_SCAN;
                    cs_d.addr  = '0;
                    cs_d.done  = 1'b0;
                end
                PH_SCAN: begin
                    cs_d.fvalid = 1'b1;
                    cs_d.fidx   = cs_q.addr;
                    cs_d.addr   = cs_q.addr + 1'b1;
                    if (cs_q.addr == LAST_IDX) begin
                        cs_d.phase = PH_DRAIN;
                    end
                end
                PH_DRAIN: begin
                    cs_d.phase = PH_DONE;
                    cs_d.done  = 1'b1;
                end
                PH_DONE: begin
                    cs_d.done = 1'b1;
                end
                default: cs_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '{phase: PH_IDLE, addr: '0, fvalid: 1'b0, fidx: '0, done: 1'b0};
        end else begin
            cs_q <= cs_d;
        end
    end

    assign rd_req    = fetch_w;
    assign rd_addr   = cs_q.addr;
    assign clear_res = start_w;
    assign cmp_valid = cs_q.fvalid;
    assign cmp_idx   = cs_q.fidx;
    assign done      = cs_q.done;
endmodule

// File: rtl/tk_rank.sv
module tk_rank #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_res,
    input  logic              cmp_valid,
    input  logic [ADDR_W-1:0] cmp_idx,
    input  logic [DATA_W-1:0] cmp_data,
    output logic [DATA_W-1:0] big_val,
    output logic [ADDR_W-1:0] big_idx,
    output logic [DATA_W-1:0] sec_val,
    output logic [ADDR_W-1:0] sec_idx
);
    typedef struct packed {
        logic [DATA_W-1:0] bv;
        logic [ADDR_W-1:0] bi;
        logic [DATA_W-1:0] sv;
        logic [ADDR_W-1:0] si;
    } rank_s;

    rank_s rk_d, rk_q;
    logic  beats_big;
    logic  beats_sec;

    assign beats_big = (cmp_data >= rk_q.bv);
    assign beats_sec = (cmp_data >= rk_q.sv);

    always_comb begin
        rk_d = rk_q;
        if (clear_res) begin
            rk_d = '0;
        end else if (cmp_valid) begin
            if (beats_big) begin
                rk_d.sv = rk_q.bv;
                rk_d.si = rk_q.bi;
                rk_d.bv = cmp_data;
                rk_d.bi = cmp_idx;
            end else if (beats_sec) begin
                rk_d.sv = cmp_data;
                rk_d.si = cmp_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rk_q <= '0;
        end else begin
            rk_q <= rk_d;
        end
    end

    assign big_val = rk_q.bv;
    assign big_idx = rk_q.bi;
    assign sec_val = rk_q.sv;
    assign sec_idx = rk_q.si;
endmodule

// File: rtl/tk_top.sv
module tk_top #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wr_en,
    input  logic              mode_run,
    input  logic              rd_en,
    output logic [DATA_W-1:0] top_val,
    output logic [DATA_W-1:0] next_val,
    output logic [ADDR_W-1:0] top_idx,
    output logic [ADDR_W-1:0] next_idx,
    output logic              done
);
    logic              rd_req_w;
    logic [ADDR_W-1:0] rd_addr_w;
    logic [DATA_W-1:0] rd_data_w;
    logic              clear_w;
    logic              cmp_valid_w;
    logic [ADDR_W-1:0] cmp_idx_w;
    logic [DATA_W-1:0] big_val_w;
    logic [ADDR_W-1:0] big_idx_w;
    logic [DATA_W-1:0] sec_val_w;
    logic [ADDR_W-1:0] sec_idx_w;
    logic              wr_req_w;

    assign wr_req_w = wr_en && !mode_run;

    tk_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_req_w),
        .wr_addr (waddr),
        .wr_data (din),
        .rd_req  (rd_req_w),
        .rd_addr (rd_addr_w),
        .rd_data (rd_data_w)
    );

    tk_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_run  (mode_run),
        .rd_req    (rd_req_w),
        .rd_addr   (rd_addr_w),
        .clear_res (clear_w),
        .cmp_valid (cmp_valid_w),
        .cmp_idx   (cmp_idx_w),
        .done      (done)
    );

    tk_rank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) rank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_res (clear_w),
        .cmp_valid (cmp_valid_w),
        .cmp_idx   (cmp_idx_w),
        .cmp_data  (rd_data_w),
        .big_val   (big_val_w),
        .big_idx   (big_idx_w),
        .sec_val   (sec_val_w),
        .sec_idx   (sec_idx_w)
    );

    assign top_val  = rd_en ? big_val_w : {DATA_W{1'bz}};
    assign next_val = rd_en ? sec_val_w : {DATA_W{1'bz}};
    assign top_idx  = rd_en ? big_idx_w : {ADDR_W{1'bz}};
    assign next_idx = rd_en ? sec_idx_w : {ADDR_W{1'bz}};
endmodule

// File: rtl/tk_check.sv
module tk_check #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_run,
    input logic              done,
    input logic              clear_res,
    input logic              cmp_valid,
    input logic [DATA_W-1:0] big_val,
    input logic [ADDR_W-1:0] big_idx,
    input logic [DATA_W-1:0] sec_val,
    input logic [ADDR_W-1:0] sec_idx
);
    assert_clear_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear_res |=> (big_val == '0 && sec_val == '0 && big_idx == '0 && sec_idx == '0));

    assert_second_not_above_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sec_val <= big_val);

    assert_max_never_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !clear_res) |=> big_val >= $past(big_val));

    assert_no_rank_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmp_valid);

    assert_done_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_run |=> !done);

    assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_run) |=> done);

    assert_results_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> ($stable(big_val) && $stable(sec_val)
                                   && $stable(big_idx) && $stable(sec_idx)));
endmodule

bind tk_top tk_check #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_run  (mode_run),
    .done      (done),
    .clear_res (clear_w),
    .cmp_valid (cmp_valid_w),
    .big_val   (big_val_w),
    .big_idx   (big_idx_w),
    .sec_val   (sec_val_w),
    .sec_idx   (sec_idx_w)
);

// File: tb/tk_top_tb_top.sv
module tk_top_tb_top;
    localparam int DW = 8;
    localparam int N  = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic [AW-1:0] waddr = '0;
    logic          wr_en = 1'b0;
    logic          mode_run = 1'b0;
    logic          rd_en = 1'b1;
    wire  [DW-1:0] top_val;
    wire  [DW-1:0] next_val;
    wire  [AW-1:0] top_idx;
    wire  [AW-1:0] next_idx;
    logic          done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [DW-1:0] tbl [N];

    always #5 clk = ~clk;

    for (genvar b = 0; b < DW; b++) begin : g_pu_val
        pullup (top_val[b]);
        pullup (next_val[b]);
    end
    for (genvar b = 0; b < AW; b++) begin : g_pu_idx
        pullup (top_idx[b]);
        pullup (next_idx[b]);
    end

    tk_top #(.DATA_W(DW), .DEPTH(N)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .waddr    (waddr),
        .wr_en    (wr_en),
        .mode_run (mode_run),
        .rd_en    (rd_en),
        .top_val  (top_val),
        .next_val (next_val),
        .top_idx  (top_idx),
        .next_idx (next_idx),
        .done     (done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_table();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            wr_en = 1'b1; waddr = AW'(i); din = tbl[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R7: done low after 33 edges from the start edge, high after 34
    task automatic run_walk(input string tag);
        @(negedge clk);
        mode_run = 1'b1;
        repeat (33) @(negedge clk);
        check({tag, " R7 done still low"}, int'(done), 0);
        @(negedge clk);
        check({tag, " R7 done high"}, int'(done), 1);
    endtask

    task automatic stop_walk();
        @(negedge clk);
        mode_run = 1'b0;
        @(negedge clk);
        check("R8 done cleared by run low", int'(done), 0);
    endtask

    // model: largest = max, last index; second = max of the rest, last index of it
    task automatic expect_top(input string tag);
        int m1, p1, m2, p2;
        m1 = -1; p1 = 0; m2 = -1; p2 = 0;
        for (int i = 0; i < N; i++) if (int'(tbl[i]) >= m1) begin m1 = int'(tbl[i]); p1 = i; end
        for (int i = 0; i < N; i++) if (i != p1 && int'(tbl[i]) >= m2) begin m2 = int'(tbl[i]); p2 = i; end
        check({tag, " R4 top_val"}, int'(top_val), m1);
        check({tag, " R4 top_idx"}, int'(top_idx), p1);
        check({tag, " R5 next_val"}, int'(next_val), m2);
        check({tag, " R5 next_idx"}, int'(next_idx), p2);
    endtask

    task automatic full_case(input string tag);
        load_table();
        run_walk(tag);
        expect_top(tag);
        stop_walk();
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 done low in reset", int'(done), 0);
        check("R9 top_val zero in reset", int'(top_val), 0);
        rst_n = 1'b1;

        // R9: empty table after reset -> all zeros, tie rule gives 31 and 30
        for (int i = 0; i < N; i++) tbl[i] = '0;
        run_walk("R9 empty");
        expect_top("R9 empty");
        check("R9 top_idx", int'(top_idx), 31);
        check("R9 next_idx", int'(next_idx), 30);
        stop_walk();

        // R1 ascending
        for (int i = 0; i < N; i++) tbl[i] = DW'(i * 7 + 3);
        full_case("R1 ascending");
        // descending
        for (int i = 0; i < N; i++) tbl[i] = DW'(250 - i * 5);
        full_case("R1 descending");
        // all equal: later index wins (R4)
        for (int i = 0; i < N; i++) tbl[i] = 8'd77;
        full_case("R4 all equal");
        // max at index 0, rest zero (R5)
        for (int i = 0; i < N; i++) tbl[i] = '0;
        tbl[0] = 8'd250;
        full_case("R5 max first");
        // duplicate maxima at 5 and 20 (R4)
        for (int i = 0; i < N; i++) tbl[i] = DW'(i);
        tbl[5] = 8'd200; tbl[20] = 8'd200;
        full_case("R4 dup max");
        // duplicated runner-up after the max (R5)
        for (int i = 0; i < N; i++) tbl[i] = 8'd10;
        tbl[3] = 8'd240; tbl[9] = 8'd90; tbl[28] = 8'd90; tbl[30] = 8'd255;
        full_case("R5 dup second");
        // extreme values 255 and 0
        for (int i = 0; i < N; i++) tbl[i] = (i % 2 == 0) ? 8'd255 : 8'd0;
        full_case("R4 extremes");
        // random sweeps
        for (int r = 0; r < 12; r++) begin
            for (int i = 0; i < N; i++) tbl[i] = DW'($urandom_range(0, (r % 3 == 0) ? 7 : 255));
            full_case("R4 random");
        end

        // R6 / R8 / R2 on one loaded table with max 200
        for (int i = 0; i < N; i++) tbl[i] = DW'(i * 3);
        tbl[12] = 8'd200;
        load_table();
        run_walk("R6 setup");
        repeat (20) @(negedge clk);
        check("R8 done holds", int'(done), 1);
        expect_top("R8 held");
        rd_en = 1'b0;
        @(negedge clk);
        check("R6 top_val floats", int'(top_val), 255);
        check("R6 next_val floats", int'(next_val), 255);
        check("R6 top_idx floats", int'(top_idx), 31);
        check("R6 next_idx floats", int'(next_idx), 31);
        check("R6 done driven", int'(done), 1);
        rd_en = 1'b1;
        // R2: write attempts during run
        wr_en = 1'b1; waddr = 5'd12; din = 8'd1;
        @(negedge clk);
        waddr = 5'd0; din = 8'd254;
        @(negedge clk);
        wr_en = 1'b0;
        stop_walk();
        run_walk("R2 rerun");
        expect_top("R2 writes ignored");
        stop_walk();

        // R10: abort mid-walk, load new table, restart
        @(negedge clk);
        mode_run = 1'b1;
        repeat (12) @(negedge clk);
        mode_run = 1'b0;
        @(negedge clk);
        check("R10 abort leaves done low", int'(done), 0);
        for (int i = 0; i < N; i++) tbl[i] = DW'(100 - i);
        full_case("R10 restart");

        // R9: reset after a finished walk empties table
        for (int i = 0; i < N; i++) tbl[i] = DW'(i + 40);
        load_table();
        run_walk("R9 pre");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clears done", int'(done), 0);
        check("R9 reset clears top_val", int'(top_val), 0);
        mode_run = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) tbl[i] = '0;
        run_walk("R9 post");
        expect_top("R9 table cleared");
        stop_walk();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule